// File: doc/BRIEF.md
# Byte-Lane Pipelined Synchronous SRAM

This block is a synchronous memory with a single read/write data path. A data word is made of four lanes. Each lane holds eight data bits and one parity bit. On a rising clock edge the block registers an access: the address, the write data and the write controls. A write then updates the array on the next edge with no further handshake. A read, or the pass-through of a write, loads an output register on that same next edge. Data therefore appears on the output one clock after the access is registered. Back-to-back accesses run at one word per clock.

Write qualification has two levels. An active-low global write stores every lane whatever the other controls are. When global write is idle, the per-lane enables are honoured only while the active-low byte-write enable is low. An access that enables no lane behaves as a read. Lanes that a write does not select keep their contents. The output enable is asynchronous. While it is high the output reads as all zeros, and the output register keeps its value.

Top module: `bytelane_sram`

## Requirements
- R1: After reset, with `oe_n` low and no access made, `rdata` is all zeros.
- R2: A read registered at clock edge t (`ce_n`=0, `gw_n`=1, `bwe_n`=1) presents the stored word at `addr` on `rdata` after edge t+1.
- R3: With `ce_n`=0 and `gw_n`=0, all four lanes are written, each with its parity bit, regardless of `bwe_n` and `be_n`. Lane i occupies bits [9i+8:9i], and its parity bit is bit 9i+8.
- R4: With `gw_n`=1 and `bwe_n`=0, lane i is written exactly when `be_n[i]`=0. Any non-empty subset of the four lanes can be written, and lanes that are not selected keep their previous contents.
- R5: With `gw_n`=1 and `bwe_n`=1, `be_n` has no effect. No lane is written, and the access returns the stored word as a read does.
- R6: A write access registered at edge t presents the full stored word after the merge on `rdata` after edge t+1 (write pass-through).
- R7: While `ce_n`=1 the other synchronous inputs are ignored. Nothing is written, and `rdata` keeps the last value loaded.
- R8: `oe_n`=1 forces `rdata` to all zeros within the same cycle, with no clock edge. Lowering it again restores the held value unchanged.
- R9: A read in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Access enable, active low, registered |
| gw_n | input | 1 | Global write, active low, registered |
| bwe_n | input | 1 | Byte-write enable, active low, registered |
| be_n | input | LANES | Per-lane write enables, active low, registered |
| addr | input | AW | Word address, registered |
| wdata | input | LANES*9 | Write data: four lanes of 8 data bits plus parity |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | LANES*9 | Read or pass-through data; zero while `oe_n` is high |

## Verification
The bench targets partial writes with irregular lane patterns. A design that merged lanes wrongly, or dropped the parity bit from its lane, would return a corrupted neighbour lane or a stale parity bit. It sets `be_n` low while `bwe_n` is high, and drives a global write together with `be_n` all high. A design that flattened the two-level qualification would write in the first case and skip lanes in the second. It reads an address in the cycle right after writing it, and checks the pass-through value of every write. An off-by-one stage would show old data here. It also checks that disabled accesses and a raised output enable leave both the array and the held output untouched.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bls_in_stage.sv
module bls_in_stage
  import bls_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [W-1:0]     wdata_q,
  output logic [LANES-1:0] mask_q
);
  // Two-level write qualification: global write wins, lane enables need bwe_n.
  function automatic logic [LANES-1:0] lane_select(input logic g_n, input logic b_n,
                                                   input logic [LANES-1:0] e_n);
    if (!g_n)      return {LANES{1'b1}};
    else if (!b_n) return ~e_n;
    else           return '0;
  endfunction

  logic [LANES-1:0] mask_d;
  op_e              op_d;

  always_comb begin
    mask_d = lane_select(gw_n, bwe_n, be_n);
    if (ce_n)             op_d = OP_IDLE;
    else if (|mask_d)     op_d = OP_WRITE;
    else                  op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      op_q <= op_d;
      if (!ce_n) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        mask_q  <= mask_d;
      end
    end
  end
endmodule

// File: rtl/bls_array.sv
module bls_array
  import bls_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  localparam int W     = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wmask,
  input  logic [W-1:0]     wword,
  input  logic [AW-1:0]    raddr,
  output logic [W-1:0]     rword
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (wmask[i]) mem[waddr][i*LANE_W +: LANE_W] <= wword[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/bls_out_stage.sv
module bls_out_stage
  import bls_pkg::*;
#(
  parameter int LANES = 4,
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_e              op_q,
  input  logic [W-1:0]     stored,
  input  logic [W-1:0]     wdata_q,
  input  logic [LANES-1:0] mask_q,
  input  logic             oe_n,
  output logic [W-1:0]     dout_q,
  output logic [W-1:0]     rdata
);
  // Word after a lane merge: selected lanes from the new data, others kept.
  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_w,
                                              input logic [W-1:0] new_w,
                                              input logic [LANES-1:0] sel);
    logic [W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*LANE_W +: LANE_W] = sel[i] ? new_w[i*LANE_W +: LANE_W] : old_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [LANES-1:0] eff_mask;
  assign eff_mask = (op_q == OP_WRITE) ? mask_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dout_q <= '0;
    else if (op_q != OP_IDLE) dout_q <= lane_merge(stored, wdata_q, eff_mask);
  end

  assign rdata = oe_n ? '0 : dout_q;
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  localparam int W    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] be_n,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  input  logic             oe_n,
  output logic [W-1:0]     rdata
);
  op_e              op_q;
  logic [AW-1:0]    addr_q;
  logic [W-1:0]     wdata_q;
  logic [LANES-1:0] mask_q;
  logic [W-1:0]     stored;
  logic [W-1:0]     dout_q;

  // Named events for the checker.
  logic acc_fire;
  logic wr_fire;
  assign acc_fire = (op_q != OP_IDLE);
  assign wr_fire  = (op_q == OP_WRITE);

  bls_in_stage #(.AW(AW), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .be_n(be_n), .addr(addr), .wdata(wdata),
    .op_q(op_q), .addr_q(addr_q), .wdata_q(wdata_q), .mask_q(mask_q)
  );

  bls_array #(.AW(AW), .LANES(LANES)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(addr_q), .wmask(mask_q), .wword(wdata_q),
    .raddr(addr_q), .rword(stored)
  );

  bls_out_stage #(.LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_n), .op_q(op_q), .stored(stored), .wdata_q(wdata_q),
    .mask_q(mask_q), .oe_n(oe_n), .dout_q(dout_q), .rdata(rdata)
  );
endmodule

// File: rtl/bls_chk.sv
module bls_chk #(
  parameter int LANES = 4,
  parameter int W     = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic             oe_n,
  input logic [W-1:0]     wdata,
  input logic [W-1:0]     rdata,
  input logic             acc_fire,
  input logic             wr_fire,
  input logic [LANES-1:0] wr_mask,
  input logic [W-1:0]     dout_q
);
  // R3
  global_write_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !gw_n) |=> (wr_fire && (&wr_mask)));

  // R5
  lane_enables_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && gw_n && bwe_n) |=> (acc_fire && !wr_fire));

  // R7
  disabled_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !acc_fire);

  // R7
  output_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> $stable(dout_q));

  // R8
  oe_blanks_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rdata == '0));

  // R6
  global_write_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !gw_n) |=> ##1 (oe_n || (rdata == $past(wdata, 2))));
endmodule

bind bytelane_sram bls_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n), .oe_n(oe_n),
  .wdata(wdata), .rdata(rdata), .acc_fire(acc_fire), .wr_fire(wr_fire),
  .wr_mask(mask_q), .dout_q(dout_q)
);

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int LANES = 4;
  localparam int W     = LANES * 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ce_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [LANES-1:0] be_n = '1;
  logic [AW-1:0]    addr = '0;
  logic [W-1:0]     wdata = '0;
  logic [W-1:0]     rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] shadow [1 << AW];
  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  bit fire1 = 1'b0, fire2 = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bytelane_sram #(.AW(AW), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .be_n(be_n), .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: one access per cycle, expected word pushed to the scoreboard.
  task automatic access(input logic g, input logic b, input logic [3:0] e,
                        input int a, input logic [W-1:0] d, input string tag);
    logic [3:0] sel;
    @(negedge clk);
    ce_n = 1'b0; gw_n = g; bwe_n = b; be_n = e; addr = AW'(a); wdata = d;
    sel = (g == 1'b0) ? 4'hF : ((b == 1'b0) ? ~e : 4'h0);
    for (int k = 0; k < LANES; k++)
      if (sel[k]) shadow[a][k*9 +: 9] = d[k*9 +: 9];
    exp_q.push_back(shadow[a]);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ce_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; be_n = '1;
    end
  endtask

  task automatic rd(input int a, input string tag);
    access(1'b1, 1'b1, 4'hF, a, {W{1'b1}}, tag);
  endtask

  // Monitor: result of an access taken at edge t is visible after edge t+1.
  always @(posedge clk) begin
    fire2 = fire1;
    fire1 = rst_n && !ce_n;
  end

  always @(negedge clk) begin
    if (fire2) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: output produced with no expected item, got %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset output", rdata, '0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", rdata, '0);

    // R3: global write overrides bwe_n and be_n; parity bits included.
    for (int i = 0; i < 8; i++)
      access(1'b0, (i % 2 == 0), 4'(i * 3), i, {4{9'(9'h1A5 ^ 9'(i * 37))}} ^ {W{i[0]}}, "R3/R6 global write");
    access(1'b0, 1'b1, 4'hF, 8, 36'h9_0000_0001, "R3 parity lanes");
    // R2: plain reads.
    for (int i = 0; i < 9; i++) rd(i, "R2 read");

    // R4: partial writes with several lane patterns.
    access(1'b1, 1'b0, 4'b1110, 0, 36'hF_FFFF_FFFF, "R4 lane0 only");
    access(1'b1, 1'b0, 4'b0101, 1, 36'h0_0000_0000, "R4 lanes 1,3");
    access(1'b1, 1'b0, 4'b0111, 2, 36'hA_5A5A_5A5A, "R4 lane3 only");
    access(1'b1, 1'b0, 4'b0000, 3, 36'h1_2345_6789, "R4 all lanes");
    access(1'b1, 1'b0, 4'b1001, 4, 36'h5_5555_5555, "R4 middle lanes");
    for (int i = 0; i < 5; i++) rd(i, "R4 readback");

    // R5: lane enables without bwe_n write nothing.
    access(1'b1, 1'b1, 4'b0000, 5, 36'h0_0000_0000, "R5 gated enables");
    rd(5, "R5 readback");

    // R9: write then read same address on consecutive cycles.
    access(1'b0, 1'b0, 4'h0, 9, 36'h7_6543_210F, "R9 write");
    rd(9, "R9 immediate read");
    access(1'b1, 1'b0, 4'b1101, 9, 36'h0_00FF_0000, "R9 partial write");
    rd(9, "R9 immediate read partial");

    // R7: disabled write ignored, output held.
    rd(6, "R7 prior read");
    @(negedge clk);
    ce_n = 1'b1; gw_n = 1'b0; bwe_n = 1'b0; be_n = '0; addr = 6'd6; wdata = '0;
    @(negedge clk);
    ce_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; be_n = '1;
    idle(3);
    check("R7 output held", rdata, shadow[6]);
    rd(6, "R7 array unchanged");
    idle(3);

    // R8: asynchronous output enable.
    held = rdata;
    #1 oe_n = 1'b1;
    #1 check("R8 output blanked", rdata, '0);
    @(negedge clk);
    check("R8 blanked across edge", rdata, '0);
    #1 oe_n = 1'b0;
    #1 check("R8 value restored", rdata, held);

    idle(4);
    check("R2 scoreboard drained", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule